// File: doc/BRIEF.md
# 1-Wire Bus Master Controller

This block drives a single open-drain 1-Wire line on behalf of a host processor. The host talks to it through a five-register file: command, data, interrupt status, interrupt enable and clock divisor. The offset of each register is shifted left by an amount fixed when the block is integrated. A command bit starts the bus reset and presence-detect sequence. Writing the data register starts a full-duplex transfer of eight time slots. Each slot sends one bit and samples the line, so sending 0xFF reads a byte back from a slave.

The transmit and receive paths each have a one-byte buffer in front of the shift logic, and each buffer and shifter has its own flag. Enabled flags are combined into one interrupt line whose polarity is programmable. The host can also hold the line low directly. All bus timing counts ticks of an external 1 MHz enable, `us_tick`. The divisor register is passed out to the prescaler that makes that tick.

Register accesses are single-cycle strobes with no back-pressure. `reg_rdata` shows the addressed register at all times. The side effects of a read happen on the clock edge where `reg_rd` is high.

Top module: `owm_master`

## Requirements
- R1: The command, data, status, enable and divisor registers sit at offsets 0, 1, 2, 3 and 4, each shifted left by ADDR_SHIFT. A write to any other address changes no register.
- R2: After reset the status register reads 0x0E (transmit buffer empty bit 2, transmit shifter empty bit 3, presence result bit 1 = "no answer"). The line is released, and `irq` is 1 because the enable register is zero and therefore selects active-low polarity.
- R3: Writing command bit 0 pulls the line low for T_RST ticks and then releases it. Command bit 0 reads back 1 until the whole reset window of 2*T_RST ticks has ended.
- R4: The line is sampled T_PSAMP ticks after release. The presence-done flag (status bit 0) sets T_RST+T_PDONE ticks after the command write. At the same time status bit 1 is written: 0 if a slave held the line low at the sample point, 1 otherwise.
- R5: Reading the status register clears the presence-done flag. Reading the data register clears the receive-buffer-full flag (status bit 4).
- R6: A data write fills the transmit buffer and clears status bit 2. On the next cycle that the bus is idle, the byte moves to the shifter: bit 2 is set again and bit 3 is cleared. Bit 3 sets again when the eighth slot ends.
- R7: Bits are sent LSB first in slots of T_SLOT ticks. The line is held low for T_LOW1 ticks to send a 1 and for T_LOW0 ticks to send a 0.
- R8: The line level is sampled T_SAMP ticks into each slot. The eight samples, LSB first, form the received byte (transmitted byte AND slave byte). It is moved to the data register with status bit 4 set.
- R9: When a byte completes while the receive buffer is still full, it waits in the receive shifter with status bit 5 set. It moves into the buffer one cycle after the buffer is read.
- R10: `irq` is active when any status bit 0, 2, 3, 4 or 5 is set together with the enable bit at the same position. Enable bit 1 = 1 makes `irq` active high; 0 makes it active low.
- R11: Command bit 2 holds the line low only while enable bit 6 is set. Command bit 3 reads the present line level.
- R12: Writing command bit 5 returns both sequencers, all buffers and all flags to their reset state on the next cycle. Any transfer in progress is aborted. The enable and divisor registers keep their values.
- R13: The divisor register stores its low 5 bits, reads them back, and drives them on `clkdiv_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | 1 MHz timing enable from the prescaler |
| reg_addr | input | AW | Register address (scaled offset) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (triggers read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Contents of the addressed register |
| owire_in | input | 1 | Sensed level of the 1-Wire line |
| owire_drive_low | output | 1 | Open-drain pull-down enable |
| irq | output | 1 | Interrupt, polarity set by enable bit 1 |
| clkdiv_cfg | output | 5 | Divisor value for the external prescaler |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle, and that the host never writes and reads the same register at once. They also take `owire_in` as the sensed line: any level is allowed, and no settling time is assumed. The stimulus uses one task per access, and each task raises exactly one strobe for one cycle. `us_tick` is held high, so every cycle counts as one microsecond. The bench slave drives the line only by pulling low, the same way a real open-drain device does.

// File: rtl/owm_pkg.sv
package owm_pkg;
  // register offsets before scaling
  localparam int OFF_CMD  = 0;
  localparam int OFF_DATA = 1;
  localparam int OFF_STAT = 2;
  localparam int OFF_IEN  = 3;
  localparam int OFF_DIV  = 4;
  // command bits
  localparam int C_BUSRST = 0;
  localparam int C_SRCH   = 1;
  localparam int C_FORCE  = 2;
  localparam int C_LINE   = 3;
  localparam int C_SWRST  = 5;
  localparam int C_OD     = 7;
  // status bits
  localparam int S_PD   = 0;
  localparam int S_PDR  = 1;
  localparam int S_TBE  = 2;
  localparam int S_TSRE = 3;
  localparam int S_RBF  = 4;
  localparam int S_RSRF = 5;
  // enable-register special bits
  localparam int E_POL = 1;
  localparam int E_DRV = 6;

  typedef enum logic [1:0] {RS_IDLE, RS_LOW, RS_REC} rs_state_e;
endpackage

// File: rtl/owm_reset_seq.sv
module owm_reset_seq
  import owm_pkg::*;
#(
  parameter int T_RST   = 625,
  parameter int T_PSAMP = 70,
  parameter int T_PDONE = 300
)(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic start,
  input  logic line_in,
  output logic busy,
  output logic drive_low,
  output logic pd_pulse,
  output logic present
);
  localparam int CW = $clog2(T_RST + 1);
  localparam logic [CW-1:0] C_END = CW'(T_RST - 1);
  localparam logic [CW-1:0] C_SMP = CW'(T_PSAMP - 1);
  localparam logic [CW-1:0] C_PD  = CW'(T_PDONE - 1);

  rs_state_e st;
  logic [CW-1:0] cnt;

  assign busy      = (st != RS_IDLE);
  assign drive_low = (st == RS_LOW);
  assign pd_pulse  = (st == RS_REC) && tick && (cnt == C_PD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RS_IDLE; cnt <= '0; present <= 1'b0;
    end else if (clr) begin
      st <= RS_IDLE; cnt <= '0; present <= 1'b0;
    end else begin
      case (st)
        RS_IDLE: if (start) begin
          st <= RS_LOW; cnt <= '0; present <= 1'b0;
        end
        RS_LOW: if (tick) begin
          if (cnt == C_END) begin st <= RS_REC; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        RS_REC: if (tick) begin
          if (cnt == C_SMP) present <= ~line_in;
          if (cnt == C_END) begin st <= RS_IDLE; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/owm_byte_engine.sv
module owm_byte_engine #(
  parameter int DW     = 8,
  parameter int T_SLOT = 70,
  parameter int T_LOW1 = 1,
  parameter int T_LOW0 = 60,
  parameter int T_SAMP = 15
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          line_in,
  output logic          busy,
  output logic          drive_low,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = $clog2(T_SLOT + 1);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] K_LAST = CW'(T_SLOT - 1);
  localparam logic [CW-1:0] K_SAMP = CW'(T_SAMP);
  localparam logic [CW-1:0] K_L1   = CW'(T_LOW1);
  localparam logic [CW-1:0] K_L0   = CW'(T_LOW0);
  localparam logic [BW-1:0] B_LAST = BW'(DW - 1);

  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] tx_sh, rx_sh;
  logic          slot_end;

  assign slot_end  = busy && tick && (cnt == K_LAST);
  assign done      = slot_end && (bidx == B_LAST);
  assign drive_low = busy && (cnt < (tx_sh[0] ? K_L1 : K_L0));
  assign rx_byte   = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; bidx <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (clr) begin
      busy <= 1'b0; cnt <= '0; bidx <= '0; tx_sh <= '0; rx_sh <= '0;
    end else if (!busy) begin
      if (load) begin
        busy <= 1'b1; cnt <= '0; bidx <= '0; tx_sh <= load_byte;
      end
    end else if (tick) begin
      if (cnt == K_SAMP) rx_sh <= {line_in, rx_sh[DW-1:1]};
      if (slot_end) begin
        cnt   <= '0;
        tx_sh <= tx_sh >> 1;
        bidx  <= bidx + 1'b1;
        if (bidx == B_LAST) busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int AW         = 8,
  parameter int ADDR_SHIFT = 0,
  parameter int T_RST      = 625,
  parameter int T_PSAMP    = 70,
  parameter int T_PDONE    = 300,
  parameter int T_SLOT     = 70,
  parameter int T_LOW1     = 1,
  parameter int T_LOW0     = 60,
  parameter int T_SAMP     = 15,
  parameter int DIVW       = 5
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            us_tick,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            owire_in,
  output logic            owire_drive_low,
  output logic            irq,
  output logic [DIVW-1:0] clkdiv_cfg
);
  localparam int DW = 8;
  localparam int EW = 7;

  function automatic logic hit(input logic [AW-1:0] a, input int off);
    return a == AW'(off << ADDR_SHIFT);
  endfunction

  logic sel_cmd, sel_data, sel_stat, sel_ien, sel_div;
  logic wr_cmd, wr_data, wr_ien, wr_div, rd_data, rd_stat, sw_rst;

  assign sel_cmd  = hit(reg_addr, OFF_CMD);
  assign sel_data = hit(reg_addr, OFF_DATA);
  assign sel_stat = hit(reg_addr, OFF_STAT);
  assign sel_ien  = hit(reg_addr, OFF_IEN);
  assign sel_div  = hit(reg_addr, OFF_DIV);
  assign wr_cmd   = reg_wr && sel_cmd;
  assign wr_data  = reg_wr && sel_data;
  assign wr_ien   = reg_wr && sel_ien;
  assign wr_div   = reg_wr && sel_div;
  assign rd_data  = reg_rd && sel_data;
  assign rd_stat  = reg_rd && sel_stat;
  assign sw_rst   = wr_cmd && reg_wdata[C_SWRST];

  // host-visible state
  logic            srch_q, od_q, force_q;
  logic [EW-1:0]   ien_q;
  logic [DIVW-1:0] div_q;
  logic [DW-1:0]   txbuf, rxsr, rxbuf;
  logic            pd_q, pdr_q, tbe_q, tsre_q, rbf_q, rsrf_q;

  // sequencer links
  logic          rs_busy, rs_drive, rs_pd, rs_present, rs_start;
  logic          eng_busy, eng_drive, eng_done, eng_load;
  logic [DW-1:0] eng_rx;

  assign rs_start = wr_cmd && reg_wdata[C_BUSRST] && !reg_wdata[C_SWRST]
                    && !rs_busy && !eng_busy;
  assign eng_load = !tbe_q && !eng_busy && !rs_busy;

  owm_reset_seq #(.T_RST(T_RST), .T_PSAMP(T_PSAMP), .T_PDONE(T_PDONE)) u_rst (
    .clk(clk), .rst_n(rst_n), .clr(sw_rst), .tick(us_tick), .start(rs_start),
    .line_in(owire_in), .busy(rs_busy), .drive_low(rs_drive),
    .pd_pulse(rs_pd), .present(rs_present));

  owm_byte_engine #(.DW(DW), .T_SLOT(T_SLOT), .T_LOW1(T_LOW1), .T_LOW0(T_LOW0),
                    .T_SAMP(T_SAMP)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(sw_rst), .tick(us_tick), .load(eng_load),
    .load_byte(txbuf), .line_in(owire_in), .busy(eng_busy),
    .drive_low(eng_drive), .done(eng_done), .rx_byte(eng_rx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch_q <= 1'b0; od_q <= 1'b0; force_q <= 1'b0;
      ien_q <= '0; div_q <= '0;
      txbuf <= '0; rxsr <= '0; rxbuf <= '0;
      pd_q <= 1'b0; pdr_q <= 1'b1; tbe_q <= 1'b1; tsre_q <= 1'b1;
      rbf_q <= 1'b0; rsrf_q <= 1'b0;
    end else if (sw_rst) begin
      srch_q <= 1'b0; od_q <= 1'b0; force_q <= 1'b0;
      txbuf <= '0; rxsr <= '0; rxbuf <= '0;
      pd_q <= 1'b0; pdr_q <= 1'b1; tbe_q <= 1'b1; tsre_q <= 1'b1;
      rbf_q <= 1'b0; rsrf_q <= 1'b0;
    end else begin
      if (wr_cmd) begin
        srch_q  <= reg_wdata[C_SRCH];
        od_q    <= reg_wdata[C_OD];
        force_q <= reg_wdata[C_FORCE];
      end
      if (wr_ien) ien_q <= reg_wdata[EW-1:0];
      if (wr_div) div_q <= reg_wdata[DIVW-1:0];

      // transmit side
      if (wr_data) begin
        txbuf <= reg_wdata;
        tbe_q <= 1'b0;
      end else if (eng_load) begin
        tbe_q <= 1'b1;
      end
      if (eng_load)      tsre_q <= 1'b0;
      else if (eng_done) tsre_q <= 1'b1;

      // receive side
      if (eng_done) begin
        rxsr   <= eng_rx;
        rsrf_q <= 1'b1;
      end else if (rsrf_q && !rbf_q) begin
        rsrf_q <= 1'b0;
      end
      if (rsrf_q && !rbf_q) begin
        rxbuf <= rxsr;
        rbf_q <= 1'b1;
      end else if (rd_data) begin
        rbf_q <= 1'b0;
      end

      // presence
      if (rs_pd) begin
        pd_q  <= 1'b1;
        pdr_q <= ~rs_present;
      end else if (rd_stat) begin
        pd_q <= 1'b0;
      end
    end
  end

  logic [7:0] cmd_view, stat_view;
  logic [5:0] irq_src;
  logic       irq_any;

  always_comb begin
    cmd_view          = '0;
    cmd_view[C_BUSRST] = rs_busy;
    cmd_view[C_SRCH]   = srch_q;
    cmd_view[C_LINE]   = owire_in;
    cmd_view[C_OD]     = od_q;
    stat_view          = '0;
    stat_view[S_PD]    = pd_q;
    stat_view[S_PDR]   = pdr_q;
    stat_view[S_TBE]   = tbe_q;
    stat_view[S_TSRE]  = tsre_q;
    stat_view[S_RBF]   = rbf_q;
    stat_view[S_RSRF]  = rsrf_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_cmd)       reg_rdata = cmd_view;
    else if (sel_data) reg_rdata = rxbuf;
    else if (sel_stat) reg_rdata = stat_view;
    else if (sel_ien)  reg_rdata[EW-1:0] = ien_q;
    else if (sel_div)  reg_rdata[DIVW-1:0] = div_q;
  end

  // bit 1 of the enable register is polarity, not a source enable
  assign irq_src = stat_view[5:0] & ien_q[5:0] & 6'b111101;
  assign irq_any = |irq_src;
  assign irq     = ien_q[E_POL] ? irq_any : ~irq_any;

  assign owire_drive_low = rs_drive | eng_drive | (force_q & ien_q[E_DRV]);
  assign clkdiv_cfg      = div_q;
endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_rst,
  input logic wr_data,
  input logic rd_data,
  input logic tbe,
  input logic tsre,
  input logic rbf,
  input logic rsrf,
  input logic pd,
  input logic rs_busy,
  input logic line_hold,
  input logic drive_low
);
  AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (tbe && tsre && !rbf && !rsrf && !pd && !rs_busy)); // R12

  AST_TBE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> !tbe); // R6

  AST_RBF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rbf) |=> !rbf); // R5

  AST_RBF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbf) |-> $past(rsrf)); // R9

  AST_PD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd) |-> rs_busy); // R4

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tsre && !rs_busy && !line_hold) |-> !drive_low); // R11
endmodule

bind owm_master owm_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_data(wr_data),
  .rd_data(rd_data), .tbe(tbe_q), .tsre(tsre_q), .rbf(rbf_q), .rsrf(rsrf_q),
  .pd(pd_q), .rs_busy(rs_busy), .line_hold(force_q & ien_q[6]),
  .drive_low(owire_drive_low));

// File: tb/owm_master_tb.sv
module owm_master_tb;
  localparam int SH = 2;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic line, drv, irq;
  logic [4:0] clkdiv_cfg;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  owm_master #(.AW(AW), .ADDR_SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .owire_in(line), .owire_drive_low(drv),
    .irq(irq), .clkdiv_cfg(clkdiv_cfg));

  // ---------------- open-drain slave model ----------------
  logic       pres_en = 1'b0;
  logic       sl_ld = 1'b0;
  logic [7:0] sl_new = 8'hFF;
  logic [7:0] sl_byte = 8'hFF;
  logic       drv_q = 1'b0;
  int low_run = 0, hold = 0, pres_t = 0, pcount = 0;
  int plen [16];
  logic slave_low;

  always @(posedge clk) begin
    drv_q <= drv;
    low_run <= drv ? low_run + 1 : 0;
    if (sl_ld) sl_byte <= sl_new;
    else if (drv && !drv_q) begin
      if (!sl_byte[0]) hold <= 30;
      sl_byte <= {1'b1, sl_byte[7:1]};
    end else if (hold > 0) hold <= hold - 1;
    if (!drv && drv_q) begin
      plen[pcount % 16] <= low_run;
      pcount <= pcount + 1;
      if (low_run >= 400 && pres_en) pres_t <= 1;
    end else if (pres_t > 0) begin
      pres_t <= (pres_t >= 200) ? 0 : pres_t + 1;
    end
  end
  assign slave_low = (hold > 0) || (pres_t >= 20 && pres_t < 140);
  assign line = !(drv || slave_low);

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [AW-1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr(input int off, input logic [7:0] d);
    wr_raw(AW'(off << SH), d);
  endtask

  task automatic rd(input int off, output logic [7:0] d);
    reg_addr = AW'(off << SH); reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic slave_set(input logic [7:0] b);
    sl_new = b; sl_ld = 1'b1;
    @(negedge clk);
    sl_ld = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_values();
    logic [7:0] v;
    rd(2, v); chk("R2 status after reset", v, 8'h0E);
    chk("R2 irq idle", irq, 1'b1);
    chk("R2 line released", drv, 1'b0);
    rd(0, v); chk("R11 line level reads high", v, 8'h08);
  endtask

  task automatic t_addr();
    logic [7:0] v;
    wr_raw(8'h01, 8'h55);
    rd(2, v); chk("R1 unscaled address ignored", v & 8'h0C, 8'h0C);
    chk("R1 no bus activity", drv, 1'b0);
  endtask

  task automatic t_div();
    logic [7:0] v;
    wr(4, 8'h15);
    rd(4, v); chk("R13 divisor readback", v, 8'h15);
    chk("R13 divisor port", clkdiv_cfg, 5'h15);
    wr(4, 8'hFF);
    rd(4, v); chk("R13 divisor width", v, 8'h1F);
  endtask

  task automatic t_irq();
    wr(3, 8'h02); chk("R10 active high, nothing pending", irq, 1'b0);
    wr(3, 8'h04); chk("R10 active low, tx empty enabled", irq, 1'b0);
    wr(3, 8'h06); chk("R10 active high, tx empty enabled", irq, 1'b1);
    wr(3, 8'h00); chk("R10 all disabled", irq, 1'b1);
  endtask

  task automatic t_force();
    logic [7:0] v;
    pres_en = 1'b0;
    wr(0, 8'h04);
    chk("R11 force ignored without enable", drv, 1'b0);
    rd(0, v); chk("R11 line high", v[3], 1'b1);
    wr(3, 8'h40);
    chk("R11 force with enable", drv, 1'b1);
    rd(0, v); chk("R11 line low readback", v[3], 1'b0);
    wr(0, 8'h00);
    chk("R11 release", drv, 1'b0);
    wr(3, 8'h00);
  endtask

  task automatic t_bus_reset(input logic present, input logic exp_pdr);
    logic [7:0] v;
    int n;
    pres_en = present;
    wr(3, 8'h03);
    wr(0, 8'h01);
    chk("R3 line low at reset start", drv, 1'b1);
    n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk("R4 presence-done timing", n, 925);
    rd(0, v); chk("R3 reset busy readback", v[0], 1'b1);
    rd(2, v);
    chk("R4 presence-done flag", v[0], 1'b1);
    chk("R4 presence result", v[1], exp_pdr);
    rd(2, v); chk("R5 status read clears presence-done", v[0], 1'b0);
    chk("R10 irq drops after clear", irq, 1'b0);
    n = 0;
    v = 8'h01;
    while (v[0] && n < 2000) begin rd(0, v); n++; end
    chk("R3 reset window ends", v[0], 1'b0);
    chk("R3 low pulse length", plen[(pcount - 1) % 16], 625);
    wr(3, 8'h00);
    pres_en = 1'b0;
  endtask

  task automatic t_xfer(input logic [7:0] tx, input logic [7:0] sl,
                        input logic [7:0] exp_rx, input bit check_pulses);
    logic [7:0] v;
    int base, n;
    slave_set(sl);
    base = pcount;
    wr(1, tx);
    rd(2, v); chk("R6 buffer full after write", v & 8'h3C, 8'h08);
    rd(2, v); chk("R6 moved to shifter", v & 8'h3C, 8'h04);
    n = 0;
    v = 8'h00;
    while (!v[4] && n < 2000) begin rd(2, v); n++; end
    chk("R6 all empty, R8 rx full", v & 8'h3C, 8'h1C);
    rd(1, v); chk("R8 received byte", v, exp_rx);
    rd(2, v); chk("R5 data read clears rx full", v[4], 1'b0);
    if (check_pulses) begin
      for (int i = 0; i < 8; i++) begin
        chk($sformatf("R7 slot %0d low time", i), plen[(base + i) % 16],
            tx[i] ? 32'd1 : 32'd60);
      end
    end
  endtask

  task automatic t_hold();
    logic [7:0] v;
    slave_set(8'hFF);
    wr(1, 8'h11);
    wr(1, 8'h22);
    repeat (2000) @(negedge clk);
    rd(2, v); chk("R9 buffer and shifter both full", v & 8'h30, 8'h30);
    rd(1, v); chk("R9 first byte", v, 8'h11);
    @(negedge clk);
    rd(2, v); chk("R9 second byte moved up", v & 8'h30, 8'h10);
    rd(1, v); chk("R9 second byte", v, 8'h22);
  endtask

  task automatic t_swrst();
    logic [7:0] v;
    slave_set(8'hFF);
    wr(1, 8'h00);
    repeat (100) @(negedge clk);
    wr(0, 8'h20);
    chk("R12 line released", drv, 1'b0);
    rd(2, v); chk("R12 flags idle", v & 8'h3D, 8'h0C);
    repeat (1500) @(negedge clk);
    rd(2, v); chk("R12 transfer aborted", v & 8'h3D, 8'h0C);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_values();
    t_addr();
    t_div();
    t_irq();
    t_force();
    t_bus_reset(1'b1, 1'b0);
    t_bus_reset(1'b0, 1'b1);
    t_xfer(8'hA5, 8'hFF, 8'hA5, 1'b1);
    t_xfer(8'hFF, 8'h3C, 8'h3C, 1'b0);
    t_xfer(8'hF0, 8'h3C, 8'h30, 1'b0);
    t_hold();
    t_swrst();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog (all R): actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule